// File: doc/BRIEF.md
# Partitioned Context-Tagged Translation Buffer

This block is a small, fully associative translation buffer. Each slot holds a key and a translation word. The key has four parts: a partition number, a flag that marks real-address (as opposed to virtual-address) mappings, a context number and a virtual page number. One request port carries one command per cycle. The command can be a lookup, an insert, a diagnostic read of a slot, a flush of every slot, or one of three selective removals. The selective removals differ in how much of the key must agree with the request.

Addresses arrive unshifted. The page is 8 KiB, so bits 12..0 of the address take no part in any comparison. A lookup or a diagnostic read answers one cycle after the request on registered outputs. Every slot carries a used bit and a lock bit. A rotating victim pointer, together with those bits, decides where an insert without an explicit slot number goes. The lock bit keeps an entry alive through a partition-wide removal.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup (op_code 0) matches a valid virtual entry only when partition, context and page number (address bits above bit 12) all agree; bits 12..0 are ignored. rsp_valid, rsp_hit, rsp_idx (lowest matching slot) and rsp_data appear on the cycle after the request, and rsp_valid stays low after any other command.
- R2: A lookup with op_real set matches only entries stored as real, on partition and page number; the context input is ignored for them. A real request never matches a virtual entry, and a virtual request never matches a real entry.
- R3: A hitting lookup with op_touch set sets the used bit of the matching slot. With op_touch clear, no used, valid or lock bit changes.
- R4: When a state update would leave every unlocked slot with its used bit set, all used bits are cleared in that same update.
- R5: An insert (op_code 1) with op_use_idx set writes key, data and op_lock into slot op_idx and marks it valid and unused. It does not move the victim pointer.
- R6: An insert with op_use_idx clear scans the slots after the victim pointer, wrapping around. It takes the first invalid slot. If there is none, it takes the first valid unlocked slot whose used bit is clear. The pointer then moves to the chosen slot, and it resets to the last slot so that slot 0 is filled first.
- R7: A diagnostic read (op_code 6) of slot op_idx returns its valid bit on rsp_hit, together with its data, used bit, lock bit and key. It changes no state.
- R8: Flush (op_code 2) invalidates every slot, locked or not.
- R9: Partition removal (op_code 3) invalidates the valid unlocked slots of op_pid. Locked slots and slots of other partitions remain.
- R10: Context removal (op_code 4) invalidates the virtual slots that match both op_pid and op_ctx, whatever their lock bit. Real slots remain.
- R11: Page removal (op_code 5) invalidates the slots that a lookup with the same inputs would hit.
- R12: When a lookup matches more than one slot, rsp_multi is raised along with rsp_hit, and rsp_idx gives the lowest matching slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 3 | 0 lookup, 1 insert, 2 flush, 3 partition removal, 4 context removal, 5 page removal, 6 read, 7 idle |
| op_va | input | VA_W | Unshifted virtual address |
| op_pid | input | PID_W | Partition number |
| op_real | input | 1 | Real-address mapping flag |
| op_ctx | input | CTX_W | Context number |
| op_touch | input | 1 | A lookup hit sets the used bit |
| op_use_idx | input | 1 | The insert goes to op_idx |
| op_idx | input | IDX_W | Slot for an explicit insert or a read |
| op_data | input | DATA_W | Translation word to insert |
| op_lock | input | 1 | Lock bit to insert |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit, or the slot is valid on a read |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_idx | output | IDX_W | Matching or read slot |
| rsp_data | output | DATA_W | Translation word of that slot |
| rsp_used | output | 1 | Used bit of that slot |
| rsp_lock | output | 1 | Lock bit of that slot |
| rsp_real | output | 1 | Real flag of that slot |
| rsp_pid | output | PID_W | Partition of that slot |
| rsp_ctx | output | CTX_W | Context of that slot |
| rsp_vpn | output | VA_W-13 | Page number of that slot |

## Verification
The assertions assume that op_code is ignored while op_valid is low. They also assume that an explicit slot number is always below the slot count. The stimulus raises op_valid for exactly one cycle per command and leaves an idle cycle between commands, and it uses explicit slot numbers only inside the eight-slot default. Duplicate keys are created on purpose, by inserting into an explicit slot. This is the only way multiple matches are produced, so that the rsp_multi check sees a known pair.

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PID_W   = 4,
  parameter int CTX_W   = 8,
  parameter int DATA_W  = 24,
  localparam int PAGE_SH = 13,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int VPN_W   = VA_W - PAGE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [VA_W-1:0]   op_va,
  input  logic [PID_W-1:0]  op_pid,
  input  logic              op_real,
  input  logic [CTX_W-1:0]  op_ctx,
  input  logic              op_touch,
  input  logic              op_use_idx,
  input  logic [IDX_W-1:0]  op_idx,
  input  logic [DATA_W-1:0] op_data,
  input  logic              op_lock,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_multi,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_used,
  output logic              rsp_lock,
  output logic              rsp_real,
  output logic [PID_W-1:0]  rsp_pid,
  output logic [CTX_W-1:0]  rsp_ctx,
  output logic [VPN_W-1:0]  rsp_vpn
);

  localparam logic [2:0] OP_LOOK = 3'd0, OP_INS = 3'd1, OP_FLUSH = 3'd2,
                         OP_RM_PART = 3'd3, OP_RM_CTX = 3'd4, OP_RM_PAGE = 3'd5,
                         OP_READ = 3'd6;

  logic [ENTRIES-1:0] vld, lck, usd, t_real;
  logic [PID_W-1:0]   t_pid  [ENTRIES];
  logic [CTX_W-1:0]   t_ctx  [ENTRIES];
  logic [VPN_W-1:0]   t_vpn  [ENTRIES];
  logic [DATA_W-1:0]  t_data [ENTRIES];
  logic [IDX_W-1:0]   rptr;

  wire [VPN_W-1:0] op_vpn = op_va[VA_W-1:PAGE_SH];
  wire unused_low_bits = ^op_va[PAGE_SH-1:0];

  wire is_look  = op_valid && op_code == OP_LOOK;
  wire is_ins   = op_valid && op_code == OP_INS;
  wire is_flush = op_valid && op_code == OP_FLUSH;
  wire is_part  = op_valid && op_code == OP_RM_PART;
  wire is_ctx   = op_valid && op_code == OP_RM_CTX;
  wire is_page  = op_valid && op_code == OP_RM_PAGE;
  wire is_read  = op_valid && op_code == OP_READ;

  logic [ENTRIES-1:0] key_hit, part_hit, ctx_hit, kill;
  logic [IDX_W-1:0]   hit_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      part_hit[i] = vld[i] && t_pid[i] == op_pid;
      ctx_hit[i]  = part_hit[i] && !t_real[i] && t_ctx[i] == op_ctx;
      key_hit[i]  = part_hit[i] && t_real[i] == op_real && t_vpn[i] == op_vpn &&
                    (op_real || t_ctx[i] == op_ctx);
    end
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (key_hit[i]) hit_idx = IDX_W'(i);
  end

  logic             inv_ok, free_ok;
  logic [IDX_W-1:0] inv_idx, free_idx, fb_idx, victim, ins_slot;
  int               scan;

  always_comb begin
    inv_ok = 1'b0; free_ok = 1'b0;
    inv_idx = '0; free_idx = '0; fb_idx = '0; scan = 0;
    for (int k = 1; k <= ENTRIES; k++) begin
      scan = int'(rptr) + k;
      if (scan >= ENTRIES) scan = scan - ENTRIES;
      if (k == 1) fb_idx = IDX_W'(scan);
      if (!inv_ok && !vld[IDX_W'(scan)]) begin
        inv_ok = 1'b1; inv_idx = IDX_W'(scan);
      end
      if (!free_ok && vld[IDX_W'(scan)] && !lck[IDX_W'(scan)] && !usd[IDX_W'(scan)]) begin
        free_ok = 1'b1; free_idx = IDX_W'(scan);
      end
    end
  end

  assign victim   = inv_ok ? inv_idx : (free_ok ? free_idx : fb_idx);
  assign ins_slot = op_use_idx ? op_idx : victim;

  always_comb begin
    kill = '0;
    if (is_flush) kill = '1;
    if (is_part)  kill = part_hit & ~lck;
    if (is_ctx)   kill = ctx_hit;
    if (is_page)  kill = key_hit;
  end

  logic [ENTRIES-1:0] vld_n, lck_n, usd_t, usd_n;

  always_comb begin
    vld_n = vld & ~kill;
    lck_n = lck & ~kill;
    usd_t = usd & ~kill;
    if (is_ins) begin
      vld_n[ins_slot] = 1'b1;
      lck_n[ins_slot] = op_lock;
      usd_t[ins_slot] = 1'b0;
    end
    if (is_look && op_touch) usd_t = usd_t | key_hit;
    usd_n = (&(usd_t | lck_n) && !(&lck_n)) ? '0 : usd_t;
  end

  wire [IDX_W-1:0] sel = is_read ? op_idx : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; lck <= '0; usd <= '0;
      rptr <= IDX_W'(ENTRIES - 1);
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_multi <= 1'b0;
      rsp_idx <= '0; rsp_data <= '0; rsp_used <= 1'b0; rsp_lock <= 1'b0;
      rsp_real <= 1'b0; rsp_pid <= '0; rsp_ctx <= '0; rsp_vpn <= '0;
    end else begin
      vld <= vld_n; lck <= lck_n; usd <= usd_n;
      if (is_ins && !op_use_idx) rptr <= victim;
      rsp_valid <= is_look || is_read;
      rsp_hit   <= is_read ? vld[op_idx] : |key_hit;
      rsp_multi <= is_look && $countones(key_hit) > 1;
      rsp_idx   <= sel;
      rsp_data  <= t_data[sel];
      rsp_used  <= usd[sel];
      rsp_lock  <= lck[sel];
      rsp_real  <= t_real[sel];
      rsp_pid   <= t_pid[sel];
      rsp_ctx   <= t_ctx[sel];
      rsp_vpn   <= t_vpn[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (is_ins) begin
      t_pid[ins_slot]  <= op_pid;
      t_real[ins_slot] <= op_real;
      t_ctx[ins_slot]  <= op_ctx;
      t_vpn[ins_slot]  <= op_vpn;
      t_data[ins_slot] <= op_data;
    end
  end

  assert_multi_has_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_multi |-> rsp_hit);

  assert_quiet_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_look && !op_touch |=> usd == $past(usd) && vld == $past(vld) && lck == $past(lck));

  assert_read_no_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> usd == $past(usd) && vld == $past(vld));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_flush |=> vld == '0);

  assert_locked_stay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_part |=> (vld & $past(lck)) == ($past(vld) & $past(lck)));

  assert_insert_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_ins |=> vld[$past(ins_slot)] && !usd[$past(ins_slot)]);

  assert_used_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (usd & ~vld) == '0);

endmodule

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 1'b0, op_real = 1'b0, op_touch = 1'b0, op_use_idx = 1'b0, op_lock = 1'b0;
  logic [2:0]  op_code = 3'd7, op_idx = '0;
  logic [31:0] op_va = '0;
  logic [3:0]  op_pid = '0;
  logic [7:0]  op_ctx = '0;
  logic [23:0] op_data = '0;
  logic        rsp_valid, rsp_hit, rsp_multi, rsp_used, rsp_lock, rsp_real;
  logic [2:0]  rsp_idx;
  logic [23:0] rsp_data;
  logic [3:0]  rsp_pid;
  logic [7:0]  rsp_ctx;
  logic [18:0] rsp_vpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_tlb u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_va(op_va),
    .op_pid(op_pid), .op_real(op_real), .op_ctx(op_ctx), .op_touch(op_touch),
    .op_use_idx(op_use_idx), .op_idx(op_idx), .op_data(op_data), .op_lock(op_lock),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi), .rsp_idx(rsp_idx),
    .rsp_data(rsp_data), .rsp_used(rsp_used), .rsp_lock(rsp_lock), .rsp_real(rsp_real),
    .rsp_pid(rsp_pid), .rsp_ctx(rsp_ctx), .rsp_vpn(rsp_vpn));

  typedef struct packed {
    logic hit; logic multi; logic [2:0] idx; logic [23:0] data;
    logic chk_ul; logic used; logic lock;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic drive(input logic [2:0] code, input logic [31:0] va, input logic [3:0] pid,
                       input logic rl, input logic [7:0] ctx, input logic touch,
                       input logic use_idx, input logic [2:0] idx, input logic [23:0] data,
                       input logic lk);
    @(negedge clk);
    op_code = code; op_va = va; op_pid = pid; op_real = rl; op_ctx = ctx;
    op_touch = touch; op_use_idx = use_idx; op_idx = idx; op_data = data; op_lock = lk;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd7;
  endtask

  task automatic ins(input logic [31:0] va, input logic [3:0] pid, input logic rl,
                     input logic [7:0] ctx, input logic [23:0] data, input logic lk);
    drive(3'd1, va, pid, rl, ctx, 1'b0, 1'b0, 3'd0, data, lk);
  endtask

  task automatic look(input logic [31:0] va, input logic [3:0] pid, input logic rl,
                      input logic [7:0] ctx, input logic touch, input logic eh,
                      input logic em, input logic [2:0] ei, input logic [23:0] ed,
                      input string tag);
    exp_q.push_back('{eh, em, ei, ed, 1'b0, 1'b0, 1'b0});
    tag_q.push_back(tag);
    drive(3'd0, va, pid, rl, ctx, touch, 1'b0, 3'd0, 24'd0, 1'b0);
  endtask

  task automatic rd(input logic [2:0] idx, input logic ev, input logic eu, input logic el,
                    input logic [23:0] ed, input string tag);
    exp_q.push_back('{ev, 1'b0, idx, ed, 1'b1, eu, el});
    tag_q.push_back(tag);
    drive(3'd6, 32'd0, 4'd0, 1'b0, 8'd0, 1'b0, 1'b0, idx, 24'd0, 1'b0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected response hit=%0b idx=%0d (expected none)", rsp_hit, rsp_idx);
      end else begin
        exp_t e; string t; bit bad;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        bad = rsp_hit !== e.hit;
        if (e.hit) bad = bad || rsp_multi !== e.multi || rsp_idx !== e.idx || rsp_data !== e.data;
        if (e.hit && e.chk_ul) bad = bad || rsp_used !== e.used || rsp_lock !== e.lock;
        if (bad) begin
          fails++;
          $display("FAIL %s: hit=%0b multi=%0b idx=%0d data=%h used=%0b lock=%0b expected hit=%0b multi=%0b idx=%0d data=%h used=%0b lock=%0b",
                   t, rsp_hit, rsp_multi, rsp_idx, rsp_data, rsp_used, rsp_lock,
                   e.hit, e.multi, e.idx, e.data, e.used, e.lock);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end (actual hung, expected completion)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R1: reset rsp_valid=%0b expected 0", rsp_valid);
    end
    rd(3'd0, 1'b0, 1'b0, 1'b0, 24'h0, "R6 reset empty");

    // R6: replacement fills from slot 0 upward
    ins(32'h0001_2000, 4'd1, 1'b0, 8'd5, 24'h0000A0, 1'b0);
    ins(32'h0003_4000, 4'd1, 1'b0, 8'd6, 24'h0000A1, 1'b0);
    ins(32'h0005_6000, 4'd1, 1'b1, 8'd9, 24'h0000A2, 1'b1);
    ins(32'h0001_2000, 4'd2, 1'b0, 8'd5, 24'h0000A3, 1'b0);
    rd(3'd0, 1'b1, 1'b0, 1'b0, 24'hA0, "R6 slot0");
    rd(3'd1, 1'b1, 1'b0, 1'b0, 24'hA1, "R6 slot1");
    rd(3'd2, 1'b1, 1'b0, 1'b1, 24'hA2, "R7 slot2 locked");
    rd(3'd3, 1'b1, 1'b0, 1'b0, 24'hA3, "R6 slot3");

    // R1 / R2 matching
    look(32'h0001_2ABC, 4'd1, 1'b0, 8'd5, 1'b0, 1'b1, 1'b0, 3'd0, 24'hA0, "R1 low bits ignored");
    look(32'h0001_2000, 4'd1, 1'b0, 8'd6, 1'b0, 1'b0, 1'b0, 3'd0, 24'h0,  "R1 context mismatch");
    look(32'h0001_2000, 4'd2, 1'b0, 8'd5, 1'b0, 1'b1, 1'b0, 3'd3, 24'hA3, "R1 partition select");
    look(32'h0005_6000, 4'd1, 1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 3'd2, 24'hA2, "R2 real ignores context");
    look(32'h0005_6000, 4'd1, 1'b0, 8'd9, 1'b0, 1'b0, 1'b0, 3'd0, 24'h0,  "R2 virtual misses real");

    // R3 used bit
    rd(3'd0, 1'b1, 1'b0, 1'b0, 24'hA0, "R3 untouched stays clear");
    look(32'h0001_2000, 4'd1, 1'b0, 8'd5, 1'b1, 1'b1, 1'b0, 3'd0, 24'hA0, "R3 touch hit");
    rd(3'd0, 1'b1, 1'b1, 1'b0, 24'hA0, "R3 used set");
    rd(3'd0, 1'b1, 1'b1, 1'b0, 24'hA0, "R7 read keeps used");
    rd(3'd1, 1'b1, 1'b0, 1'b0, 24'hA1, "R7 other slot clear");

    // R5 explicit slot, R12 duplicate
    drive(3'd1, 32'h0001_2000, 4'd1, 1'b0, 8'd5, 1'b0, 1'b1, 3'd6, 24'h0000B6, 1'b0);
    look(32'h0001_2000, 4'd1, 1'b0, 8'd5, 1'b0, 1'b1, 1'b1, 3'd0, 24'hA0, "R12 multi match");
    rd(3'd6, 1'b1, 1'b0, 1'b0, 24'hB6, "R5 explicit slot");

    // R11 page removal
    drive(3'd5, 32'h0001_2000, 4'd1, 1'b0, 8'd5, 1'b0, 1'b0, 3'd0, 24'h0, 1'b0);
    rd(3'd0, 1'b0, 1'b0, 1'b0, 24'h0, "R11 removed slot0");
    rd(3'd6, 1'b0, 1'b0, 1'b0, 24'h0, "R11 removed slot6");
    rd(3'd3, 1'b1, 1'b0, 1'b0, 24'hA3, "R11 other partition kept");

    // R5 pointer untouched by explicit insert: next victim after 3 is 4
    ins(32'h0007_8000, 4'd1, 1'b0, 8'd6, 24'h0000A4, 1'b0);
    rd(3'd4, 1'b1, 1'b0, 1'b0, 24'hA4, "R5 pointer not moved");

    // R10 context removal
    drive(3'd4, 32'h0, 4'd1, 1'b0, 8'd6, 1'b0, 1'b0, 3'd0, 24'h0, 1'b0);
    rd(3'd1, 1'b0, 1'b0, 1'b0, 24'h0, "R10 ctx slot1 removed");
    rd(3'd4, 1'b0, 1'b0, 1'b0, 24'h0, "R10 ctx slot4 removed");
    rd(3'd2, 1'b1, 1'b0, 1'b1, 24'hA2, "R10 real slot kept");

    // R9 partition removal
    ins(32'h0009_A000, 4'd1, 1'b0, 8'd7, 24'h0000A5, 1'b1);
    ins(32'h000B_C000, 4'd1, 1'b0, 8'd7, 24'h0000A6, 1'b0);
    rd(3'd6, 1'b1, 1'b0, 1'b0, 24'hA6, "R6 slot6 chosen");
    drive(3'd3, 32'h0, 4'd1, 1'b0, 8'd0, 1'b0, 1'b0, 3'd0, 24'h0, 1'b0);
    rd(3'd6, 1'b0, 1'b0, 1'b0, 24'h0, "R9 unlocked removed");
    rd(3'd2, 1'b1, 1'b0, 1'b1, 24'hA2, "R9 locked kept");
    rd(3'd5, 1'b1, 1'b0, 1'b1, 24'hA5, "R9 locked kept");
    rd(3'd3, 1'b1, 1'b0, 1'b0, 24'hA3, "R9 other partition kept");

    // R6 fill order 7,0,1,4,6 then used-aware choice
    for (int k = 0; k < 5; k++)
      ins(32'h0010_0000 + 32'(k) * 32'h2000, 4'd3, 1'b0, 8'd1, 24'h0000C0 + 24'(k), 1'b0);
    look(32'h0010_0000, 4'd3, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 3'd7, 24'hC0, "R6 fill slot7");
    look(32'h0010_2000, 4'd3, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 3'd0, 24'hC1, "R6 fill slot0");
    look(32'h0010_4000, 4'd3, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 3'd1, 24'hC2, "R6 fill slot1");
    look(32'h0010_6000, 4'd3, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 3'd4, 24'hC3, "R6 fill slot4");
    look(32'h0010_8000, 4'd3, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 3'd6, 24'hC4, "R6 fill slot6");
    ins(32'h0020_0000, 4'd3, 1'b0, 8'd1, 24'h0000D0, 1'b0);
    rd(3'd3, 1'b1, 1'b0, 1'b0, 24'hD0, "R6 unused slot replaced");
    rd(3'd7, 1'b1, 1'b1, 1'b0, 24'hC0, "R3 used before clear");
    look(32'h0001_2000, 4'd2, 1'b0, 8'd5, 1'b0, 1'b0, 1'b0, 3'd0, 24'h0, "R6 evicted entry misses");

    // R4 automatic clear
    look(32'h0020_0000, 4'd3, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 3'd3, 24'hD0, "R4 last unused touched");
    rd(3'd7, 1'b1, 1'b0, 1'b0, 24'hC0, "R4 used cleared slot7");
    rd(3'd3, 1'b1, 1'b0, 1'b0, 24'hD0, "R4 used cleared slot3");
    ins(32'h0030_0000, 4'd3, 1'b0, 8'd1, 24'h0000E0, 1'b0);
    rd(3'd4, 1'b1, 1'b0, 1'b0, 24'hE0, "R6 next after pointer");
    look(32'h0010_6000, 4'd3, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 3'd0, 24'h0, "R6 overwritten misses");

    // R8 flush
    drive(3'd2, 32'h0, 4'd0, 1'b0, 8'd0, 1'b0, 1'b0, 3'd0, 24'h0, 1'b0);
    rd(3'd2, 1'b0, 1'b0, 1'b0, 24'h0, "R8 locked flushed");
    rd(3'd5, 1'b0, 1'b0, 1'b0, 24'h0, "R8 locked flushed");
    look(32'h0005_6000, 4'd1, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0, 3'd0, 24'h0, "R8 lookup after flush");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R1: %0d responses missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule